// File: doc/BRIEF.md
# Exception Vector Entry Generator

This block works out where a CPU core goes when it takes a trap. It keeps a status copy of the level-sensitive interrupt lines and combines it with a local enable mask. When a trap request arrives, it selects the winning interrupt or uses the supplied exception cause. It then forms the next program counter and the cause-code write that goes with it.

Entry points sit at a programmable spacing above a general base address. The spacing is a power of two set by a 3-bit selector, and a zero selector places every entry on the base itself. Interrupt entries sit above the exception entries, at a code offset set by a parameter. A TLB-refill exception bypasses the spacing and goes to a separate refill base, and it leaves the cause field unwritten. An interrupt taken while the core is in debug mode raises a debug-interrupt flag and takes the debug path in place of normal vectoring. An interrupt request that finds nothing pending raises an error and does not redirect.

All results are registered. They appear one cycle after the request strobe as single-cycle pulses, and the target address and code are held until the next request.

Top module: `exc_vector_gen`

## Requirements
- R1: Each bit of `irq_status` follows its `irq_lines` bit with one clock of delay: it is 1 while the line is high and 0 while it is low. Reset clears all status bits.
- R2: The entry spacing is 0 bytes when `spacing_sel` is 0. For a nonzero value v it is 2^(v+2) bytes, which ranges from 8 to 512.
- R3: The pending set is `irq_status & irq_enable`. The selected interrupt is the highest-numbered bit of that set.
- R4: An interrupt request (`take_is_irq`=1) outside debug mode with a nonempty pending set redirects to `gen_base + (EXT_BASE + index) * spacing`, modulo 2^ADDR_W. It writes the code `EXT_BASE + index`.
- R5: A non-interrupt request (`take_is_irq`=0) without refill redirects to `gen_base + take_cause * spacing`, modulo 2^ADDR_W, and writes `take_cause` as the code.
- R6: A non-interrupt request with `take_refill`=1 redirects to `refill_base` whatever the spacing is, and does not write the code (`code_wr_en`=0).
- R7: An interrupt request while `dbg_mode`=1 pulses `dbg_irq_set` with no redirect, no code write and no error. This holds even when nothing is pending.
- R8: An interrupt request outside debug mode with an empty pending set pulses `irq_err` with no redirect and no code write.
- R9: Results appear one cycle after `take_req`. At most one of `redirect_valid`, `dbg_irq_set` and `irq_err` is high in a cycle. A cycle without a request leaves all strobes, including `code_wr_en`, low on the next cycle.
- R10: `dbg_mode` has no effect on non-interrupt requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IRQ | Level-sensitive interrupt lines |
| irq_enable | input | NUM_IRQ | Local interrupt enable mask |
| spacing_sel | input | 3 | Entry spacing selector |
| gen_base | input | ADDR_W | General entry base address |
| refill_base | input | ADDR_W | TLB-refill entry base address |
| take_req | input | 1 | Trap request strobe |
| take_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| take_cause | input | CODE_W | Exception cause code |
| take_refill | input | 1 | Exception is a TLB refill |
| dbg_mode | input | 1 | Core is in debug mode |
| irq_status | output | NUM_IRQ | Latched interrupt status bits |
| redirect_valid | output | 1 | Pulse: new program counter is valid |
| redirect_pc | output | ADDR_W | Target program counter |
| code_wr_en | output | 1 | Pulse: write the exception-code field |
| code_wr_val | output | CODE_W | Value for the exception-code field |
| dbg_irq_set | output | 1 | Pulse: set the debug-interrupt flag and take the debug path |
| irq_err | output | 1 | Pulse: interrupt requested with nothing pending |

## Verification
Interrupt requests are swept over every pattern of the interrupt lines for every spacing value under three enable masks. Empty pending sets separate the error path from a redirect, and the masks show that enables, not raw lines, decide the winner. Exceptions are swept over every cause and spacing with refill and debug mode both toggled, which separates scaled vectoring from the fixed refill entry and shows debug mode leaves exceptions alone. A base near the top of the address space shows the sum wraps, and a debug-mode sweep that includes empty pending sets shows the debug path outranks the error.

// File: rtl/excvec_pkg.sv
package excvec_pkg;

    typedef enum logic [1:0] {
        TK_NONE     = 2'd0,
        TK_REDIRECT = 2'd1,
        TK_DEBUG    = 2'd2,
        TK_ERROR    = 2'd3
    } take_kind_e;

    typedef struct packed {
        take_kind_e kind;
        logic       code_we;
        logic       use_refill;
    } take_ctl_t;

    localparam int SHIFT_W = 4;

    // Byte spacing is 1 << (sel + 2) for a nonzero selector.
    function automatic logic [SHIFT_W-1:0] spacing_shift(input logic [2:0] sel);
        return SHIFT_W'(sel) + SHIFT_W'(2);
    endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] lines,
    output logic [NUM_IRQ-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= lines;
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] pending,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_IRQ-1:0] hit;

    // A bit wins when it is set and nothing above it is set.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_hit
        if (i == NUM_IRQ - 1) begin : g_top
            assign hit[i] = pending[i];
        end else begin : g_low
            assign hit[i] = pending[i] & ~(|pending[NUM_IRQ-1:i+1]);
        end
    end

    assign any = |pending;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            idx = idx | (hit[i] ? IDX_W'(i) : '0);
        end
    end
endmodule

// File: rtl/vec_addr_calc.sv
module vec_addr_calc
    import excvec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    input  logic [2:0]        spacing_sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0]  code_ext;
    logic [ADDR_W-1:0]  offset;
    logic [SHIFT_W-1:0] sh;

    assign code_ext = ADDR_W'(code);
    assign sh       = spacing_shift(spacing_sel);
    assign offset   = (spacing_sel == 3'd0) ? '0 : (code_ext << sh);
    assign addr     = base + offset;
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import excvec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_IRQ  = 8,
    parameter int CODE_W   = 6,
    // EXT_BASE + NUM_IRQ - 1 must fit in CODE_W bits
    parameter int EXT_BASE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [2:0]         spacing_sel,
    input  logic [ADDR_W-1:0]  gen_base,
    input  logic [ADDR_W-1:0]  refill_base,
    input  logic               take_req,
    input  logic               take_is_irq,
    input  logic [CODE_W-1:0]  take_cause,
    input  logic               take_refill,
    input  logic               dbg_mode,
    output logic [NUM_IRQ-1:0] irq_status,
    output logic               redirect_valid,
    output logic [ADDR_W-1:0]  redirect_pc,
    output logic               code_wr_en,
    output logic [CODE_W-1:0]  code_wr_val,
    output logic               dbg_irq_set,
    output logic               irq_err
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] pending;
    logic               pend_any;
    logic [IDX_W-1:0]   sel_idx;
    logic [CODE_W-1:0]  irq_code;
    logic [CODE_W-1:0]  eff_code;
    logic [ADDR_W-1:0]  vec_pc;
    logic [ADDR_W-1:0]  next_pc;
    take_ctl_t          ctl;

    irq_status_reg #(.NUM_IRQ(NUM_IRQ)) u_status (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .status (irq_status)
    );

    assign pending = irq_status & irq_enable;

    irq_prio_sel #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
        .pending (pending),
        .any     (pend_any),
        .idx     (sel_idx)
    );

    assign irq_code = CODE_W'(EXT_BASE) + CODE_W'(sel_idx);
    assign eff_code = take_is_irq ? irq_code : take_cause;

    vec_addr_calc #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_addr (
        .base        (gen_base),
        .code        (eff_code),
        .spacing_sel (spacing_sel),
        .addr        (vec_pc)
    );

    always_comb begin
        ctl = '{kind: TK_NONE, code_we: 1'b0, use_refill: 1'b0};
        if (take_req) begin
            if (take_is_irq) begin
                if (dbg_mode)       ctl.kind = TK_DEBUG;
                else if (!pend_any) ctl.kind = TK_ERROR;
                else begin
                    ctl.kind    = TK_REDIRECT;
                    ctl.code_we = 1'b1;
                end
            end else if (take_refill) begin
                ctl.kind       = TK_REDIRECT;
                ctl.use_refill = 1'b1;
            end else begin
                ctl.kind    = TK_REDIRECT;
                ctl.code_we = 1'b1;
            end
        end
    end

    assign next_pc = ctl.use_refill ? refill_base : vec_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            code_wr_en     <= 1'b0;
            dbg_irq_set    <= 1'b0;
            irq_err        <= 1'b0;
            redirect_pc    <= '0;
            code_wr_val    <= '0;
        end else begin
            redirect_valid <= (ctl.kind == TK_REDIRECT);
            code_wr_en     <= ctl.code_we;
            dbg_irq_set    <= (ctl.kind == TK_DEBUG);
            irq_err        <= (ctl.kind == TK_ERROR);
            if (take_req) begin
                redirect_pc <= next_pc;
                code_wr_val <= eff_code;
            end
        end
    end

    // ---------------- assertions ----------------
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r1_status_tracks: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> irq_status == $past(irq_lines));

    a_r3_winner_pending: assert property (@(posedge clk) disable iff (rst)
        pend_any |-> pending[sel_idx]);

    a_r5_exc_code: assert property (@(posedge clk) disable iff (rst)
        take_req && !take_is_irq && !take_refill |=>
            redirect_valid && code_wr_en && code_wr_val == $past(take_cause));

    a_r6_refill: assert property (@(posedge clk) disable iff (rst)
        take_req && !take_is_irq && take_refill |=>
            redirect_valid && !code_wr_en && redirect_pc == $past(refill_base));

    a_r7_debug: assert property (@(posedge clk) disable iff (rst)
        take_req && take_is_irq && dbg_mode |=>
            dbg_irq_set && !redirect_valid && !code_wr_en && !irq_err);

    a_r8_empty: assert property (@(posedge clk) disable iff (rst)
        take_req && take_is_irq && !dbg_mode && pending == '0 |=>
            irq_err && !redirect_valid && !code_wr_en);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({redirect_valid, dbg_irq_set, irq_err}));

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !take_req |=> !redirect_valid && !code_wr_en && !dbg_irq_set && !irq_err);

    a_r2_zero_spacing: assert property (@(posedge clk) disable iff (rst)
        take_req && spacing_sel == 3'd0 && !take_refill && !dbg_mode |=>
            (!redirect_valid || redirect_pc == $past(gen_base)));

endmodule

// File: tb/exc_vector_gen_tb.sv
module exc_vector_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 32;
    localparam int NUM_IRQ  = 8;
    localparam int CODE_W   = 6;
    localparam int EXT_BASE = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_IRQ-1:0] irq_lines;
    logic [NUM_IRQ-1:0] irq_enable;
    logic [2:0]         spacing_sel;
    logic [ADDR_W-1:0]  gen_base;
    logic [ADDR_W-1:0]  refill_base;
    logic               take_req;
    logic               take_is_irq;
    logic [CODE_W-1:0]  take_cause;
    logic               take_refill;
    logic               dbg_mode;
    logic [NUM_IRQ-1:0] irq_status;
    logic               redirect_valid;
    logic [ADDR_W-1:0]  redirect_pc;
    logic               code_wr_en;
    logic [CODE_W-1:0]  code_wr_val;
    logic               dbg_irq_set;
    logic               irq_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_gen #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .CODE_W(CODE_W),
                     .EXT_BASE(EXT_BASE)) u_dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .irq_enable(irq_enable),
        .spacing_sel(spacing_sel), .gen_base(gen_base), .refill_base(refill_base),
        .take_req(take_req), .take_is_irq(take_is_irq), .take_cause(take_cause),
        .take_refill(take_refill), .dbg_mode(dbg_mode), .irq_status(irq_status),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .code_wr_en(code_wr_en), .code_wr_val(code_wr_val),
        .dbg_irq_set(dbg_irq_set), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] base,
                                                   input int code, input int v);
        logic [63:0] off;
        off = (v == 0) ? 64'd0 : (64'(code) << (v + 2));
        return base + off[ADDR_W-1:0];
    endfunction

    // One trap: set lines, let them latch, strobe, check result, check idle.
    task automatic run_take(input logic is_irq, input logic [NUM_IRQ-1:0] lines,
                            input logic [NUM_IRQ-1:0] en, input int v,
                            input logic [ADDR_W-1:0] base, input int cause,
                            input logic refill, input logic dbg);
        logic [NUM_IRQ-1:0] pend;
        int idx;
        logic e_valid, e_we, e_dbg, e_err;
        logic [ADDR_W-1:0] e_pc;
        int e_code;
        @(negedge clk);
        irq_lines = lines;
        @(negedge clk);
        check("R1 status", 64'(irq_status), 64'(lines));
        irq_enable  = en;
        spacing_sel = 3'(v);
        gen_base    = base;
        take_is_irq = is_irq;
        take_cause  = CODE_W'(cause);
        take_refill = refill;
        dbg_mode    = dbg;
        take_req    = 1'b1;
        pend = lines & en;
        idx = 0;
        for (int i = 0; i < NUM_IRQ; i++) if (pend[i]) idx = i;
        e_valid = 0; e_we = 0; e_dbg = 0; e_err = 0; e_pc = '0; e_code = 0;
        if (is_irq) begin
            if (dbg) e_dbg = 1;                      // R7
            else if (pend == 0) e_err = 1;           // R8
            else begin                               // R3, R4, R2
                e_valid = 1; e_we = 1; e_code = EXT_BASE + idx;
                e_pc = exp_addr(base, EXT_BASE + idx, v);
            end
        end else if (refill) begin                   // R6
            e_valid = 1; e_pc = refill_base;
        end else begin                               // R5, R10, R2
            e_valid = 1; e_we = 1; e_code = cause;
            e_pc = exp_addr(base, cause, v);
        end
        @(negedge clk);
        take_req = 1'b0;
        check("R9 redirect_valid", 64'(redirect_valid), 64'(e_valid));
        check("R7 dbg_irq_set", 64'(dbg_irq_set), 64'(e_dbg));
        check("R8 irq_err", 64'(irq_err), 64'(e_err));
        check(is_irq ? "R4 code_wr_en" : "R6 code_wr_en", 64'(code_wr_en), 64'(e_we));
        if (e_valid)
            check(is_irq ? "R4 redirect_pc" : (refill ? "R6 redirect_pc" : "R5 redirect_pc"),
                  64'(redirect_pc), 64'(e_pc));
        if (e_we)
            check(is_irq ? "R3 code_wr_val" : "R5 code_wr_val",
                  64'(code_wr_val), 64'(e_code));
        @(negedge clk);
        check("R9 idle strobes", 64'({redirect_valid, code_wr_en, dbg_irq_set, irq_err}), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [NUM_IRQ-1:0] masks [3];
        masks[0] = 8'hFF; masks[1] = 8'h0F; masks[2] = 8'hA5;
        rst = 1'b1;
        irq_lines = '0; irq_enable = '0; spacing_sel = '0; gen_base = '0;
        refill_base = 32'h0000_8A40; take_req = 0; take_is_irq = 0;
        take_cause = '0; take_refill = 0; dbg_mode = 0;
        repeat (3) @(negedge clk);
        // R1/R9 reset state
        check("R1 reset status", 64'(irq_status), 64'd0);
        check("R9 reset strobes",
              64'({redirect_valid, code_wr_en, dbg_irq_set, irq_err}), 64'd0);
        rst = 1'b0;

        // Interrupt sweep: R2 R3 R4 R8
        for (int v = 0; v < 8; v++)
            for (int m = 0; m < 3; m++)
                for (int l = 0; l < 256; l++)
                    run_take(1'b1, 8'(l), masks[m], v,
                             (l % 2) ? 32'hFFFF_FE00 : 32'h0000_1000, 0, 1'b0, 1'b0);

        // Exception sweep: R2 R5 R6 R10
        for (int v = 0; v < 8; v++)
            for (int c = 0; c < 64; c++)
                for (int k = 0; k < 4; k++)
                    run_take(1'b0, 8'h00, 8'hFF, v,
                             (c % 3 == 0) ? 32'hFFFF_F000 : 32'h0002_0000, c,
                             k[0], k[1]);

        // Debug sweep: R7, including empty pending sets
        for (int l = 0; l < 256; l += 17)
            run_take(1'b1, 8'(l), 8'hFF, l % 8, 32'h0000_4000, 0, 1'b0, 1'b1);
        run_take(1'b1, 8'h00, 8'h00, 3, 32'h0000_4000, 0, 1'b0, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule